// File: doc/BRIEF.md
# Token Packet Decoder

This block sits behind a serial receive front end that has already removed line coding and stuffed bits, and hands over one byte per valid beat. The first beat of a packet carries a start mark and the last carries an end mark; these may be the same beat. The decoder looks at the identifier byte. It recognises the three host token kinds, which are host-to-device data (OUT), device-to-host data (IN) and control setup (SETUP). It then gathers the 7-bit device address and the 4-bit endpoint, checks the 5-bit token CRC, and compares the address with the device address held on an input.

One cycle after the end beat it raises exactly one of four outcomes, or none: an accepted token with its kind and endpoint, an identifier error, a CRC error, or a length error. Packets that are not tokens, and tokens for other devices, produce nothing. A new start mark at any point abandons the packet in progress.

The control is a six-state machine. The states are IDLE (outside a packet), PID (a token identifier has been seen), BODY (the address byte has been seen), LONG (a token has run past three bytes), SKIP (a non-token packet is being passed over) and BADPID (the identifier failed its check). Transitions happen only on valid beats. A start beat leaves any state for PID, SKIP or BADPID, or for IDLE when the start beat is also the end beat. From PID, the second byte leads to BODY. From BODY, a third byte that is not an end leads to LONG. An end beat in PID, BODY, LONG, SKIP or BADPID returns to IDLE and gives that state's verdict. Non-start beats seen in IDLE leave it in IDLE.

Top module: `token_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, tok_valid, err_pid, err_crc and err_len are all low.
- R2: A three-byte packet whose identifier is a token with a correct check nibble, whose CRC is correct and whose address equals dev_addr raises tok_valid for one cycle after the end beat. tok_kind is 0 for OUT (type 0001), 1 for IN (type 1001) and 2 for SETUP (type 1101). The type sits in bits 3:0 of the first byte.
- R3: Field positions: byte 1 bits 6:0 are the address and byte 1 bit 7 is endpoint bit 0. Byte 2 bits 2:0 are endpoint bits 3:1. Byte 2 bits 7:3 carry the CRC field, and tok_endp reports the 4-bit endpoint rebuilt from these bits.
- R4: The CRC uses x^5+x^2+1 with an all-ones start over the 11 body bits, address bit 0 first. Byte 2 bit 3+i holds the complement of remainder bit 4-i. Any mismatch in a three-byte token raises err_crc and no tok_valid.
- R5: If bits 7:4 of the first byte are not the bitwise complement of bits 3:0, err_pid is raised after the end beat. This holds whatever the length, and it takes priority over all other outcomes.
- R6: A token identifier in a packet of any length other than three bytes raises err_len, with no tok_valid and no err_crc.
- R7: A correct token whose address differs from dev_addr raises nothing. With dev_addr at 0, tokens sent to address 0 are accepted.
- R8: A packet with a valid check nibble and a non-token type raises nothing, whatever its length.
- R9: A start beat in the middle of a packet discards that packet. Valid beats outside a packet are ignored.
- R10: At most one output pulse follows each end beat. None appears without an end beat, and tok_valid never stays high for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_start | input | 1 | This byte opens a packet |
| in_end | input | 1 | This byte closes a packet |
| in_data | input | 8 | Received byte, first-received bit in bit 0 |
| dev_addr | input | 7 | Address this device answers to |
| tok_valid | output | 1 | One-cycle pulse: accepted token |
| tok_kind | output | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP |
| tok_endp | output | 4 | Endpoint of the accepted token |
| err_pid | output | 1 | One-cycle pulse: identifier check failed |
| err_crc | output | 1 | One-cycle pulse: token CRC failed |
| err_len | output | 1 | One-cycle pulse: token not three bytes long |

## Verification
The bench aims at the precedence among the outcomes. A bad check nibble on a packet that also has a bad CRC or a bad length must report only err_pid. A decoder that tested the CRC first would report err_crc instead. One- and four-byte tokens go after the length rule. A design that read the CRC from whatever byte came third, or that stopped counting after three bytes, would accept the four-byte token. Endpoints with only the low bit or only the high bits set expose a split endpoint field wired the wrong way round. Mid-packet restarts, stray beats and non-token packets of odd lengths catch a machine that leaks state between packets or flags non-token traffic.

// File: rtl/token_decoder_pkg.sv
package token_decoder_pkg;

    typedef enum logic [1:0] {
        KIND_OUT   = 2'd0,
        KIND_IN    = 2'd1,
        KIND_SETUP = 2'd2,
        KIND_NONE  = 2'd3
    } tok_kind_e;

    localparam logic [3:0] TYPE_OUT   = 4'b0001;
    localparam logic [3:0] TYPE_IN    = 4'b1001;
    localparam logic [3:0] TYPE_SETUP = 4'b1101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PID,
        ST_BODY,
        ST_LONG,
        ST_SKIP,
        ST_BADPID
    } dec_state_e;

endpackage

// File: rtl/token_pid_check.sv
module token_pid_check
    import token_decoder_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] pid_byte,
    output logic              pid_ok,
    output logic              pid_token,
    output tok_kind_e         pid_kind
);
    localparam int NIB_W = BYTE_W / 2;

    logic [NIB_W-1:0] type_nib;
    logic [NIB_W-1:0] chk_nib;

    assign type_nib = pid_byte[NIB_W-1:0];
    assign chk_nib  = pid_byte[BYTE_W-1:NIB_W];
    assign pid_ok   = (chk_nib == ~type_nib);

    always_comb begin
        pid_token = 1'b1;
        pid_kind  = KIND_NONE;
        unique case (type_nib)
            TYPE_OUT:   pid_kind = KIND_OUT;
            TYPE_IN:    pid_kind = KIND_IN;
            TYPE_SETUP: pid_kind = KIND_SETUP;
            default:    pid_token = 1'b0;
        endcase
    end
endmodule

// File: rtl/token_crc5_check.sv
module token_crc5_check #(
    parameter int               BODY_W = 11,
    parameter int               CRC_W  = 5,
    parameter logic [CRC_W-1:0] POLY   = 5'b00101,
    parameter logic [CRC_W-1:0] INIT   = 5'b11111,
    parameter logic [CRC_W-1:0] RESID  = 5'b01100
) (
    input  logic [BODY_W+CRC_W-1:0] wire_bits,
    output logic                    crc_ok
);
    localparam int N_BITS = BODY_W + CRC_W;

    logic [CRC_W-1:0] stage [0:N_BITS];
    assign stage[0] = INIT;

    for (genvar g = 0; g < N_BITS; g++) begin : g_shift
        logic fb;
        assign fb = wire_bits[g] ^ stage[g][CRC_W-1];
        assign stage[g+1] = {stage[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_ok = (stage[N_BITS] == RESID);
endmodule

// File: rtl/token_fsm.sv
module token_fsm
    import token_decoder_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 7,
    parameter int ENDP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic              in_end,
    input  logic [BYTE_W-1:0] in_data,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              pid_ok,
    input  logic              pid_token,
    input  tok_kind_e         pid_kind,
    input  logic              crc_ok,
    output logic [BYTE_W-1:0] addr_byte,
    output logic              tok_valid,
    output tok_kind_e         tok_kind,
    output logic [ENDP_W-1:0] tok_endp,
    output logic              err_pid,
    output logic              err_crc,
    output logic              err_len
);
    localparam int ENDP_LO_W = BYTE_W - ADDR_W;
    localparam int ENDP_HI_W = ENDP_W - ENDP_LO_W;

    dec_state_e        state, nxt;
    tok_kind_e         kind_q;
    logic [BYTE_W-1:0] byte1_q;
    logic              v_tok, v_pid, v_crc, v_len;
    logic              addr_hit;
    logic [ENDP_W-1:0] endp_now;

    assign addr_byte = byte1_q;
    assign addr_hit  = (byte1_q[ADDR_W-1:0] == dev_addr);
    assign endp_now  = {in_data[ENDP_HI_W-1:0], byte1_q[BYTE_W-1 -: ENDP_LO_W]};

    // state register and captured fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind_q  <= KIND_NONE;
            byte1_q <= '0;
        end else begin
            state <= nxt;
            if (in_valid && in_start) begin
                kind_q <= pid_kind;
            end
            if (in_valid && !in_start && state == ST_PID) begin
                byte1_q <= in_data;
            end
        end
    end

    // next state and verdict
    always_comb begin
        nxt   = state;
        v_tok = 1'b0;
        v_pid = 1'b0;
        v_crc = 1'b0;
        v_len = 1'b0;
        if (in_valid) begin
            if (in_start) begin
                if (!pid_ok) begin
                    v_pid = in_end;
                    nxt   = in_end ? ST_IDLE : ST_BADPID;
                end else if (!pid_token) begin
                    nxt = in_end ? ST_IDLE : ST_SKIP;
                end else begin
                    v_len = in_end;
                    nxt   = in_end ? ST_IDLE : ST_PID;
                end
            end else begin
                unique case (state)
                    ST_IDLE: nxt = ST_IDLE;
                    ST_PID: begin
                        v_len = in_end;
                        nxt   = in_end ? ST_IDLE : ST_BODY;
                    end
                    ST_BODY: begin
                        if (in_end) begin
                            nxt   = ST_IDLE;
                            v_crc = !crc_ok;
                            v_tok = crc_ok && addr_hit;
                        end else begin
                            nxt = ST_LONG;
                        end
                    end
                    ST_LONG: begin
                        v_len = in_end;
                        nxt   = in_end ? ST_IDLE : ST_LONG;
                    end
                    ST_SKIP: begin
                        nxt = in_end ? ST_IDLE : ST_SKIP;
                    end
                    ST_BADPID: begin
                        v_pid = in_end;
                        nxt   = in_end ? ST_IDLE : ST_BADPID;
                    end
                    default: nxt = ST_IDLE;
                endcase
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_valid <= 1'b0;
            err_pid   <= 1'b0;
            err_crc   <= 1'b0;
            err_len   <= 1'b0;
            tok_kind  <= KIND_NONE;
            tok_endp  <= '0;
        end else begin
            tok_valid <= v_tok;
            err_pid   <= v_pid;
            err_crc   <= v_crc;
            err_len   <= v_len;
            if (v_tok) begin
                tok_kind <= kind_q;
                tok_endp <= endp_now;
            end
        end
    end
endmodule

// File: rtl/token_decoder.sv
module token_decoder
    import token_decoder_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 7,
    parameter int ENDP_W = 4,
    parameter int CRC_W  = 5,
    parameter logic [CRC_W-1:0] CRC_POLY  = 5'b00101,
    parameter logic [CRC_W-1:0] CRC_INIT  = 5'b11111,
    parameter logic [CRC_W-1:0] CRC_RESID = 5'b01100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic              in_end,
    input  logic [BYTE_W-1:0] in_data,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              tok_valid,
    output logic [1:0]        tok_kind,
    output logic [ENDP_W-1:0] tok_endp,
    output logic              err_pid,
    output logic              err_crc,
    output logic              err_len
);
    localparam int BODY_W = ADDR_W + ENDP_W;

    logic              pid_ok, pid_token, crc_ok;
    tok_kind_e         pid_kind, kind_out;
    logic [BYTE_W-1:0] addr_byte;

    token_pid_check #(.BYTE_W(BYTE_W)) u_pid (
        .pid_byte  (in_data),
        .pid_ok    (pid_ok),
        .pid_token (pid_token),
        .pid_kind  (pid_kind)
    );

    token_crc5_check #(
        .BODY_W (BODY_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY),
        .INIT   (CRC_INIT),
        .RESID  (CRC_RESID)
    ) u_crc (
        .wire_bits ({in_data, addr_byte}),
        .crc_ok    (crc_ok)
    );

    token_fsm #(
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W),
        .ENDP_W (ENDP_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .in_end    (in_end),
        .in_data   (in_data),
        .dev_addr  (dev_addr),
        .pid_ok    (pid_ok),
        .pid_token (pid_token),
        .pid_kind  (pid_kind),
        .crc_ok    (crc_ok),
        .addr_byte (addr_byte),
        .tok_valid (tok_valid),
        .tok_kind  (kind_out),
        .tok_endp  (tok_endp),
        .err_pid   (err_pid),
        .err_crc   (err_crc),
        .err_len   (err_len)
    );

    assign tok_kind = kind_out;
endmodule

// File: rtl/token_decoder_chk.sv
module token_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_start,
    input logic       in_end,
    input logic       tok_valid,
    input logic [1:0] tok_kind,
    input logic       err_pid,
    input logic       err_crc,
    input logic       err_len
);
    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({tok_valid, err_pid, err_crc, err_len}) <= 1);

    assert_needs_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid || err_pid || err_crc || err_len) |-> $past(in_valid && in_end));

    assert_tok_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |=> !tok_valid);

    assert_short_no_tok_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_start && in_end) |-> (!tok_valid && !err_crc));

    assert_kind_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |-> (tok_kind != 2'd3));

    assert_tok_not_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |-> $past(!in_start));
endmodule

bind token_decoder token_decoder_chk u_chk (.*);

// File: tb/token_decoder_tb.sv
module token_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [6:0] dev_addr = 7'h00;
    logic       tok_valid, err_pid, err_crc, err_len;
    logic [1:0] tok_kind;
    logic [3:0] tok_endp;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] pkt [0:5];
    int         pkt_n;
    logic       e_tok, e_pid, e_crc, e_len;
    logic [1:0] e_kind;
    logic [3:0] e_endp;

    always #5 clk = ~clk;

    token_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_end(in_end), .in_data(in_data), .dev_addr(dev_addr),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_endp(tok_endp),
        .err_pid(err_pid), .err_crc(err_crc), .err_len(err_len)
    );

    function automatic logic [4:0] crc_field(input logic [10:0] body);
        logic [4:0] r = 5'b11111;
        logic [4:0] f;
        for (int i = 0; i < 11; i++) begin
            logic fb = body[i] ^ r[4];
            r = {r[3:0], 1'b0};
            if (fb) r = r ^ 5'b00101;
        end
        for (int i = 0; i < 5; i++) f[i] = ~r[4-i];
        return f;
    endfunction

    task automatic make_token(input logic [3:0] typ, input logic [6:0] a, input logic [3:0] ep);
        pkt[0] = {~typ, typ};
        pkt[1] = {ep[0], a};
        pkt[2] = {crc_field({ep, a}), ep[3:1]};
        pkt_n = 3;
    endtask

    task automatic predict();
        logic [3:0] t = pkt[0][3:0];
        logic tokp = (t == 4'b0001) || (t == 4'b1001) || (t == 4'b1101);
        e_tok = 0; e_pid = 0; e_crc = 0; e_len = 0; e_kind = 2'd3; e_endp = 4'd0;
        if (pkt[0][7:4] != ~t) e_pid = 1;
        else if (!tokp) ;
        else if (pkt_n != 3) e_len = 1;
        else if (pkt[2][7:3] != crc_field({pkt[2][2:0], pkt[1]})) e_crc = 1;
        else if (pkt[1][6:0] == dev_addr) begin
            e_tok = 1;
            e_kind = (t == 4'b0001) ? 2'd0 : (t == 4'b1001) ? 2'd1 : 2'd2;
            e_endp = {pkt[2][2:0], pkt[1][7]};
        end
    endtask

    task automatic beat(input logic [7:0] d, input logic s, input logic e);
        in_valid = 1; in_data = d; in_start = s; in_end = e;
        @(negedge clk);
        in_valid = 0; in_start = 0; in_end = 0;
    endtask

    task automatic send(input int gap);
        for (int i = 0; i < pkt_n; i++) begin
            beat(pkt[i], i == 0, i == pkt_n - 1);
            if (i < pkt_n - 1) repeat (gap) @(negedge clk);
        end
    endtask

    task automatic check(input string req);
        logic ok;
        total++;
        ok = (tok_valid == e_tok) && (err_pid == e_pid) && (err_crc == e_crc) &&
             (err_len == e_len) && (!e_tok || (tok_kind == e_kind && tok_endp == e_endp));
        if (!ok) begin
            bad++;
            $display("FAIL %s: got tok=%0b kind=%0d endp=%0h pid=%0b crc=%0b len=%0b exp tok=%0b kind=%0d endp=%0h pid=%0b crc=%0b len=%0b",
                     req, tok_valid, tok_kind, tok_endp, err_pid, err_crc, err_len,
                     e_tok, e_kind, e_endp, e_pid, e_crc, e_len);
        end
    endtask

    task automatic expect_quiet(input string req);
        e_tok = 0; e_pid = 0; e_crc = 0; e_len = 0;
        check(req);
    endtask

    task automatic run(input string req, input int gap);
        predict();
        send(gap);
        check(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        expect_quiet("R1 in reset");
        rst_n = 1;
        @(negedge clk);
        expect_quiet("R1 after reset");

        dev_addr = 7'h2A;
        make_token(4'b0001, 7'h2A, 4'h5); run("R2 OUT accepted", 0);
        make_token(4'b1001, 7'h2A, 4'h0); run("R2 IN accepted", 2);
        make_token(4'b1101, 7'h2A, 4'hC); run("R2 SETUP accepted", 1);
        make_token(4'b1001, 7'h2A, 4'h1); run("R3 endpoint low bit", 0);
        make_token(4'b1001, 7'h2A, 4'hE); run("R3 endpoint high bits", 0);
        @(negedge clk);
        expect_quiet("R10 pulse cleared");

        make_token(4'b0001, 7'h2A, 4'h3); pkt[2] ^= 8'h20; run("R4 crc bit flipped", 0);
        make_token(4'b0001, 7'h2A, 4'h3); pkt[1] ^= 8'h04; run("R4 address bit flipped", 0);

        make_token(4'b1001, 7'h2A, 4'h3); pkt[0] = 8'h19; pkt_n = 1; run("R5 bad pid single byte", 0);
        make_token(4'b1001, 7'h2A, 4'h3); pkt[0] = 8'h79; pkt[2] ^= 8'h80; run("R5 bad pid beats bad crc", 0);
        make_token(4'b1001, 7'h2A, 4'h3); pkt[0] = 8'h09; pkt[3] = 8'h55; pkt_n = 4; run("R5 bad pid beats length", 0);

        make_token(4'b0001, 7'h2A, 4'h3); pkt_n = 1; run("R6 one-byte token", 0);
        make_token(4'b0001, 7'h2A, 4'h3); pkt_n = 2; run("R6 two-byte token", 0);
        make_token(4'b0001, 7'h2A, 4'h3); pkt[3] = 8'hA5; pkt_n = 4; run("R6 four-byte token", 0);

        make_token(4'b0001, 7'h15, 4'h3); run("R7 other address silent", 0);
        dev_addr = 7'h00;
        make_token(4'b1101, 7'h00, 4'h0); run("R7 default address zero", 0);
        make_token(4'b1101, 7'h01, 4'h0); run("R7 address one ignored at zero", 0);

        pkt[0] = 8'hD2; pkt_n = 1; run("R8 handshake ignored", 0);
        pkt[0] = 8'hC3; pkt[1] = 8'h11; pkt[2] = 8'h22; pkt[3] = 8'h33; pkt_n = 4; run("R8 data packet ignored", 0);
        pkt[0] = 8'h4B; pkt[1] = 8'h00; pkt[2] = 8'h00; pkt_n = 3; run("R8 three-byte non-token ignored", 0);

        beat(8'hAB, 0, 0); beat(8'h12, 0, 1); beat(8'h34, 0, 0);
        expect_quiet("R9 stray beats ignored");
        make_token(4'b1001, 7'h00, 4'h9);
        beat(pkt[0], 1, 0); beat(pkt[1], 0, 0);
        run("R9 restart mid packet", 0);
        make_token(4'b1001, 7'h00, 4'h9);
        beat(8'h19, 1, 0);
        run("R9 restart after bad pid", 0);

        for (int n = 0; n < 400; n++) begin
            logic [3:0] t;
            if ($urandom_range(0, 9) == 0) dev_addr = 7'($urandom);
            case ($urandom_range(0, 9))
                0, 1, 2: t = 4'b0001;
                3, 4:    t = 4'b1001;
                5, 6:    t = 4'b1101;
                default: t = 4'($urandom);
            endcase
            make_token(t, ($urandom_range(0, 1) == 1) ? dev_addr : 7'($urandom), 4'($urandom));
            if ($urandom_range(0, 6) == 0) pkt[0][7:4] = 4'($urandom);
            if ($urandom_range(0, 4) == 0) pkt_n = $urandom_range(1, 6);
            for (int k = 3; k < 6; k++) pkt[k] = 8'($urandom);
            if ($urandom_range(0, 4) == 0) pkt[$urandom_range(1, 2)][$urandom_range(0, 7)] ^= 1'b1;
            run("R2 R4 R5 R6 R7 R8 R10 random", $urandom_range(0, 2));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule